// File: doc/BRIEF.md
# Dual-Loop Phase-Frequency Detector with Lock Monitor

This block serves two phase-locked loops that share one reference oscillator clock. For each loop it compares a reference pulse train with the divided feedback pulse train. It turns their rising edges into a pump command: drive high, drive low, or leave the filter node floating. A per-loop polarity input swaps the meaning of high and low so that either VCO slope and either filter type can be used. The detector is edge-triggered and keeps its state across cycles, so it also steers a loop that is off in frequency. When the two edges coincide, both pump lines are still pulsed for one clock, which removes the dead zone around lock.

Each loop also has a lock monitor. It counts oscillator clocks between the two edges of each comparison cycle. The lock flag drops as soon as that count reaches the unlock threshold, even if the later edge has not arrived yet. The flag rises only after three consecutive cycles stay inside the lock window. A per-loop sleep input forces the pump lines idle, clears the loop state and reports that loop as locked. A combined output is the AND of both loop flags.

All inputs are synchronous to `clk`, which is the reference oscillator clock. Pump encoding for each loop: `pump_hi`=1 drives the output high, `pump_lo`=1 drives it low, both 0 means high impedance, and both 1 is the balanced one-clock anti-dead-zone pulse.

Top module: `pfd_lockmon`

## Requirements
- R1: With `pol`=1, a reference edge leading the feedback edge by d clocks (d≥0) gives `pump_hi` for d+1 clocks and `pump_lo` for 1 clock. A feedback edge leading by d gives `pump_lo` for d+1 clocks and `pump_hi` for 1 clock.
- R2: With `pol`=0 the two lines are swapped: a reference lead of d gives `pump_lo` for d+1 clocks and `pump_hi` for 1 clock, and a feedback lead gives the reverse.
- R3: Edges captured on the same clock give both lines high for exactly one clock. Both lines are never high on two consecutive clocks.
- R4: With no edges on either input, both pump lines stay 0 (high impedance).
- R5: The phase error is the number of clocks between the two edges. `lock` rises at the clock that closes the third consecutive cycle whose error is at most LOCK_TH and below UNLOCK_TH (defaults 4 and 2).
- R6: `lock` falls on the clock where the running error count of an open cycle reaches UNLOCK_TH, before the later edge arrives.
- R7: A cycle that fails the window restarts qualification, so three new consecutive good cycles are needed.
- R8: While `sleep` is 1 for a loop, its pump lines are 0 whatever edges arrive, and its `lock` bit reads 1.
- R9: When `sleep` returns to 0, that loop's `lock` reads 0 and qualification restarts from zero.
- R10: `lock_all` is 1 only when every loop is locked or asleep.
- R11: After reset, with `sleep` low, all pump lines, `lock` and `lock_all` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr | input | NLOOP | Reference pulse train per loop |
| fp | input | NLOOP | Divided feedback pulse train per loop |
| pol | input | NLOOP | Polarity select per loop (1: reference lead drives high) |
| sleep | input | NLOOP | Power-save per loop |
| pump_hi | output | NLOOP | Drive-high command per loop |
| pump_lo | output | NLOOP | Drive-low command per loop |
| lock | output | NLOOP | Lock flag per loop |
| lock_all | output | 1 | AND of all loop lock flags |

## Verification
The bench counts pump-line clocks over whole comparison cycles for both edge orders and both polarities. A swapped polarity mux or an off-by-one in the reset path shows up as the wrong pulse lengths. It samples the lock flag in the middle of an open cycle with a large error, so a design that drops lock only when the cycle closes still reads 1 there and is caught. It inserts one bad cycle among good ones and passes through sleep while qualification is saturated. A design that does not clear the consecutive count would then re-lock one or two cycles early. The combined flag is checked with one loop asleep and the other locked, awake-unlocked or unlocking, which catches an OR in place of an AND and a sleeping loop that is not treated as locked.

// File: rtl/pfd_lockmon.sv
module pfd_lockmon #(
  parameter int NLOOP     = 2,
  parameter int ERR_W     = 8,
  parameter int UNLOCK_TH = 2,
  parameter int LOCK_TH   = 4,
  parameter int QUAL_N    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLOOP-1:0] fr,
  input  logic [NLOOP-1:0] fp,
  input  logic [NLOOP-1:0] pol,
  input  logic [NLOOP-1:0] sleep,
  output logic [NLOOP-1:0] pump_hi,
  output logic [NLOOP-1:0] pump_lo,
  output logic [NLOOP-1:0] lock,
  output logic             lock_all
);

  localparam int QW = $clog2(QUAL_N + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;
  localparam logic [ERR_W-1:0] UNL = ERR_W'(UNLOCK_TH);
  localparam logic [ERR_W-1:0] LKT = ERR_W'(LOCK_TH);
  localparam logic [QW-1:0]    QN  = QW'(QUAL_N);

  for (genvar g = 0; g < NLOOP; g++) begin : g_loop
    logic             fr_q, fp_q, up_st, dn_st, lk;
    logic             fr_ev, fp_ev, both, one, over, good;
    logic [ERR_W-1:0] err, err_inc;
    logic [QW-1:0]    qual;

    assign fr_ev   = fr[g] & ~fr_q;
    assign fp_ev   = fp[g] & ~fp_q;
    assign both    = up_st & dn_st;
    assign one     = up_st ^ dn_st;
    assign err_inc = (err == ERR_MAX) ? err : err + 1'b1;
    assign over    = one && (err_inc >= UNL);
    assign good    = (err <= LKT) && (err < UNL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fr_q  <= 1'b0;
        fp_q  <= 1'b0;
        up_st <= 1'b0;
        dn_st <= 1'b0;
        err   <= '0;
        qual  <= '0;
        lk    <= 1'b0;
      end else begin
        fr_q <= fr[g];
        fp_q <= fp[g];
        if (sleep[g]) begin
          up_st <= 1'b0;
          dn_st <= 1'b0;
          err   <= '0;
          qual  <= '0;
          lk    <= 1'b0;
        end else begin
          up_st <= both ? fr_ev : (up_st | fr_ev);
          dn_st <= both ? fp_ev : (dn_st | fp_ev);
          if (both)
            err <= '0;
          else if (one)
            err <= err_inc;
          if (over) begin
            lk   <= 1'b0;
            qual <= '0;
          end else if (both) begin
            if (good) begin
              if (qual >= QN - 1'b1) lk <= 1'b1;
              if (qual != QN) qual <= qual + 1'b1;
            end else begin
              qual <= '0;
            end
          end
        end
      end
    end

    assign pump_hi[g] = ~sleep[g] & (pol[g] ? up_st : dn_st);
    assign pump_lo[g] = ~sleep[g] & (pol[g] ? dn_st : up_st);
    assign lock[g]    = sleep[g] | lk;
  end

  assign lock_all = &lock;

endmodule

// File: rtl/pfd_lockmon_chk.sv
module pfd_lockmon_chk #(
  parameter int NLOOP = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NLOOP-1:0] sleep,
  input logic [NLOOP-1:0] pump_hi,
  input logic [NLOOP-1:0] pump_lo,
  input logic [NLOOP-1:0] lock,
  input logic             lock_all
);

  for (genvar g = 0; g < NLOOP; g++) begin : g_chk
    p_save_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sleep[g] |-> (!pump_hi[g] && !pump_lo[g]));

    p_save_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sleep[g] |-> lock[g]);

    p_short_balanced_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pump_hi[g] && pump_lo[g]) |=> !(pump_hi[g] && pump_lo[g]));

    p_lock_at_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep[g] && $past(!sleep[g]) && $rose(lock[g])) |-> $past(pump_hi[g] && pump_lo[g]));

    p_wake_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sleep[g]) && !sleep[g]) |-> !lock[g]);
  end

  p_all_asleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (&sleep) |-> lock_all);

endmodule

bind pfd_lockmon pfd_lockmon_chk #(.NLOOP(NLOOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .pump_hi(pump_hi),
  .pump_lo(pump_lo), .lock(lock), .lock_all(lock_all)
);

// File: tb/sim_pfd_lockmon.sv
`timescale 1ns/1ps
module sim_pfd_lockmon;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fr = '0, fp = '0, pol = 2'b11, sleep = '0;
  logic [1:0] pump_hi, pump_lo, lock;
  logic lock_all;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pfd_lockmon u0 (
    .clk(clk), .rst_n(rst_n), .fr(fr), .fp(fp), .pol(pol), .sleep(sleep),
    .pump_hi(pump_hi), .pump_lo(pump_lo), .lock(lock), .lock_all(lock_all)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp_cycle(int lp, int d, output int nh, output int nl, output int lk_mid);
    nh = 0; nl = 0; lk_mid = 0;
    for (int t = 0; t < 16; t++) begin
      fr[lp] = (t == 4);
      fp[lp] = (t == 4 + d);
      step();
      nh += pump_hi[lp];
      nl += pump_lo[lp];
      if (t == 6) lk_mid = lock[lp];
    end
  endtask

  task automatic t_reset();
    check("R11 pump_hi after reset", pump_hi, 0);
    check("R11 pump_lo after reset", pump_lo, 0);
    check("R11 lock after reset", lock, 0);
    check("R11 lock_all after reset", lock_all, 0);
  endtask

  task automatic t_idle();
    int nh = 0, nl = 0;
    for (int t = 0; t < 16; t++) begin
      step();
      nh += pump_hi[0] + pump_hi[1];
      nl += pump_lo[0] + pump_lo[1];
    end
    check("R4 idle hi", nh, 0);
    check("R4 idle lo", nl, 0);
  endtask

  task automatic t_pol1();
    int nh, nl, m;
    pol[0] = 1'b1;
    cmp_cycle(0, 3, nh, nl, m);
    check("R1 ref lead hi", nh, 4);
    check("R1 ref lead lo", nl, 1);
    cmp_cycle(0, -2, nh, nl, m);
    check("R1 fb lead hi", nh, 1);
    check("R1 fb lead lo", nl, 3);
  endtask

  task automatic t_pol0();
    int nh, nl, m;
    pol[0] = 1'b0;
    cmp_cycle(0, 3, nh, nl, m);
    check("R2 ref lead hi", nh, 1);
    check("R2 ref lead lo", nl, 4);
    cmp_cycle(0, -2, nh, nl, m);
    check("R2 fb lead hi", nh, 3);
    check("R2 fb lead lo", nl, 1);
    pol[0] = 1'b1;
  endtask

  task automatic t_zero();
    int nh, nl, m;
    cmp_cycle(0, 0, nh, nl, m);
    check("R3 equal hi", nh, 1);
    check("R3 equal lo", nl, 1);
  endtask

  task automatic t_lock();
    int nh, nl, m;
    cmp_cycle(0, 5, nh, nl, m);
    check("R5 after bad cycle", lock[0], 0);
    cmp_cycle(0, 1, nh, nl, m);
    check("R5 one good", lock[0], 0);
    cmp_cycle(0, -1, nh, nl, m);
    check("R5 two good", lock[0], 0);
    cmp_cycle(0, 1, nh, nl, m);
    check("R5 three good", lock[0], 1);
  endtask

  task automatic t_unlock();
    int nh, nl, m;
    cmp_cycle(0, 6, nh, nl, m);
    check("R6 lock mid-cycle", m, 0);
    check("R6 lock after cycle", lock[0], 0);
  endtask

  task automatic t_requal();
    int nh, nl, m;
    cmp_cycle(0, 1, nh, nl, m);
    cmp_cycle(0, 1, nh, nl, m);
    check("R7 two good", lock[0], 0);
    cmp_cycle(0, 5, nh, nl, m);
    cmp_cycle(0, 1, nh, nl, m);
    cmp_cycle(0, 1, nh, nl, m);
    check("R7 two good after break", lock[0], 0);
    cmp_cycle(0, 0, nh, nl, m);
    check("R7 three good after break", lock[0], 1);
  endtask

  task automatic t_save();
    int nh, nl, m;
    cmp_cycle(0, 1, nh, nl, m);
    sleep[0] = 1'b1;
    cmp_cycle(0, 3, nh, nl, m);
    check("R8 sleep hi", nh, 0);
    check("R8 sleep lo", nl, 0);
    check("R8 sleep lock", lock[0], 1);
    check("R10 both asleep", lock_all, 1);
  endtask

  task automatic t_wake();
    int nh, nl, m;
    sleep[0] = 1'b0;
    #1;
    check("R9 wake lock", lock[0], 0);
    cmp_cycle(0, 1, nh, nl, m);
    check("R9 wake one good", lock[0], 0);
    cmp_cycle(0, 1, nh, nl, m);
    check("R9 wake two good", lock[0], 0);
    cmp_cycle(0, 1, nh, nl, m);
    check("R9 wake three good", lock[0], 1);
  endtask

  task automatic t_combined();
    int nh, nl, m;
    check("R10 locked and asleep", lock_all, 1);
    sleep[1] = 1'b0;
    step();
    check("R10 other awake unlocked", lock_all, 0);
    sleep[1] = 1'b1;
    step();
    check("R10 asleep again", lock_all, 1);
    cmp_cycle(0, 6, nh, nl, m);
    check("R10 loop0 unlocked", lock_all, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
    t_reset();
    t_idle();
    sleep[1] = 1'b1;
    t_pol1();
    t_pol0();
    t_zero();
    t_lock();
    t_unlock();
    t_requal();
    t_save();
    t_wake();
    t_combined();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule